// File: doc/BRIEF.md
# Double-Buffered Overlay Plane Register Bank

This block holds the configuration of one display overlay plane. Every register exists twice: a pending copy that software writes through a single-cycle write port, and an active copy that the display pipeline consumes. A pending value reaches the active copy only when it has been armed and a vertical-blank pulse arrives. This lets a whole frame's worth of changes take effect together, between two frames.

Arming is decided per register. A write to the surface-address register arms every register written since the last transfer. The tile-offset, linear-offset, combined-offset and colour-conversion registers arm themselves. The control register arms itself only while the active plane-enable bit is clear. Once the plane is running, a control change waits for a surface write like the rest. A readback port returns active copies, so software can see when an update has landed. An update-pending flag is high from the first arm event until the transfer.

Each register slot runs a three-state machine: SLOT_IDLE (pending equals active), SLOT_HELD (written, not armed) and SLOT_ARMED (will transfer on the next vertical blank). The transitions are IDLE/HELD to ARMED on a self-arming write or on a surface write, IDLE to HELD on a write that does not arm, and ARMED to IDLE on a vertical blank. A write in that same cycle instead leads to HELD or ARMED for the following pulse. A bank-level machine with states ARM_IDLE and ARM_WAIT drives the pending flag. It goes ARM_IDLE to ARM_WAIT on any arm event, and ARM_WAIT to ARM_IDLE on a vertical blank that carries no new arm event.

Top module: `plane_dbuf_regs`

## Requirements
- R1: After reset every active register reads 0, `plane_on` is 0 and `upd_pending` is 0.
- R2: Active copies change only at a clock edge where `vblank` is 1. A value written in the same cycle as a `vblank` pulse does not take effect at that pulse, but at the next one.
- R3: A write to the surface register (address 1) arms every register written since the last transfer, including itself. All of them become active together at the next vertical blank.
- R4: A control write (address 0) arms itself when active control bit 31 (plane enable) is 0. When that bit is 1, the write stays pending until a surface write arms it.
- R5: The tile-offset (5), linear-offset (6), combined-offset (7) and colour-conversion (11) registers arm themselves on write, with no surface write.
- R6: A register that was written but not armed keeps its previous active value across vertical blanks. A register that was not written keeps its active value through any transfer.
- R7: `upd_pending` rises the cycle after any arm event. It falls after the vertical blank that transfers, unless a new arm event happens in that same cycle.
- R8: The addresses are: stride 2, position 3, size 4, colour-key low 8, colour-key high 9, colour-key mask 10 and scaler 12. `rd_data` returns the active copy of the register at `rd_addr`, and reads 0 for addresses 13 to 15. Writes to addresses 13 to 15 have no effect and arm nothing.
- R9: Position, tile-offset and combined-offset hold y in bits 31:16 and x in bits 15:0. `disp_x`/`disp_y` come from active position. Size holds height minus one in bits 31:16 and width minus one in bits 15:0, and `disp_w`/`disp_h` give the true width and height.
- R10: The disable sequence is control 0, then scaler 0, then surface 0, on a running plane. It leaves the plane on until the first vertical blank after the surface write, when control, scaler and surface all become 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 4 | Register address for the write |
| wr_data | input | 32 | Write data into the pending copy |
| vblank | input | 1 | Vertical-blank pulse, transfer point |
| rd_addr | input | 4 | Readback address |
| rd_data | output | 32 | Active copy at `rd_addr` |
| act_ctrl | output | 32 | Active control |
| act_surf | output | 32 | Active surface address |
| act_stride | output | 32 | Active stride |
| act_pos | output | 32 | Active position |
| act_size | output | 32 | Active size |
| act_tileoff | output | 32 | Active tile offset |
| act_linoff | output | 32 | Active linear offset |
| act_offset | output | 32 | Active combined offset |
| act_key_lo | output | 32 | Active colour-key low value |
| act_key_hi | output | 32 | Active colour-key high value |
| act_key_mask | output | 32 | Active colour-key channel mask |
| act_csc | output | 32 | Active colour-conversion coefficient |
| act_scale | output | 32 | Active scaler setting |
| plane_on | output | 1 | Active enable bit |
| disp_x | output | 16 | Active x position |
| disp_y | output | 16 | Active y position |
| disp_w | output | 17 | Active width (field plus one) |
| disp_h | output | 17 | Active height (field plus one) |
| upd_pending | output | 1 | Armed update waiting for vertical blank |

## Verification
The bench writes a register in the very cycle of a vertical-blank pulse. A design that transfers same-cycle data would show the new value one frame early, and one that drops the write would never show it. It writes control on an enabled plane and on a disabled one. Treating control as always self-arming would turn the plane off before its surface write, and never self-arming would leave a fresh enable stuck. It also checks that stride and scaler, written without a surface write, survive several blanks unchanged, which catches a design that arms every write. It checks that the pending flag stays high when a new arm coincides with the transfer, which catches a flag cleared unconditionally.

// File: rtl/plane_dbuf_pkg.sv
package plane_dbuf_pkg;

    localparam int unsigned NUM_REGS = 13;

    typedef enum int unsigned {
        REG_CTRL    = 0,
        REG_SURF    = 1,
        REG_STRIDE  = 2,
        REG_POS     = 3,
        REG_SIZE    = 4,
        REG_TILEOFF = 5,
        REG_LINOFF  = 6,
        REG_OFFSET  = 7,
        REG_KEYLO   = 8,
        REG_KEYHI   = 9,
        REG_KEYMASK = 10,
        REG_CSC     = 11,
        REG_SCALE   = 12
    } reg_idx_e;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_HELD  = 2'd1,
        SLOT_ARMED = 2'd2
    } slot_state_e;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_WAIT = 1'b1
    } bank_state_e;

    // Registers whose own write is enough to arm them.
    function automatic bit is_self_arming(input int unsigned idx);
        return (idx == REG_TILEOFF) || (idx == REG_LINOFF) ||
               (idx == REG_OFFSET)  || (idx == REG_CSC);
    endfunction

endpackage

// File: rtl/plane_wr_decode.sv
module plane_wr_decode
    import plane_dbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                ctrl_enabled,
    output logic [NUM_REGS-1:0] wr_hit,
    output logic [NUM_REGS-1:0] self_arm,
    output logic                bank_arm,
    output logic                arm_evt
);

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_dec
        assign wr_hit[gi] = wr_en && (wr_addr == ADDR_W'(gi));
        if (gi == REG_CTRL) begin : g_ctrl
            // control arms itself only on a plane that is not yet running
            assign self_arm[gi] = !ctrl_enabled;
        end else if (gi == REG_SURF) begin : g_surf
            assign self_arm[gi] = 1'b1;
        end else if (is_self_arming(gi)) begin : g_self
            assign self_arm[gi] = 1'b1;
        end else begin : g_wait
            assign self_arm[gi] = 1'b0;
        end
    end

    assign bank_arm = wr_hit[REG_SURF];
    assign arm_evt  = bank_arm || (|(wr_hit & self_arm));

endmodule

// File: rtl/plane_reg_slot.sv
module plane_reg_slot
    import plane_dbuf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              self_arm,
    input  logic              bank_arm,
    input  logic              vblank,
    output logic [DATA_W-1:0] active_o,
    output logic              armed_o
);

    slot_state_e       state_q, state_d;
    slot_state_e       after_xfer;
    logic [DATA_W-1:0] pend_q, pend_d;
    logic [DATA_W-1:0] act_q, act_d;

    // next-state process
    always_comb begin
        after_xfer = state_q;
        act_d      = act_q;
        unique case (state_q)
            SLOT_IDLE:  after_xfer = SLOT_IDLE;
            SLOT_HELD:  after_xfer = SLOT_HELD;
            SLOT_ARMED: begin
                if (vblank) begin
                    act_d      = pend_q;
                    after_xfer = SLOT_IDLE;
                end
            end
            default:    after_xfer = SLOT_IDLE;
        endcase

        state_d = after_xfer;
        pend_d  = pend_q;
        if (wr_hit) begin
            pend_d = wr_data;
            if (self_arm || after_xfer == SLOT_ARMED)
                state_d = SLOT_ARMED;
            else
                state_d = SLOT_HELD;
        end
        if (bank_arm && state_d == SLOT_HELD)
            state_d = SLOT_ARMED;
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            pend_q  <= '0;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            act_q   <= act_d;
        end
    end

    // output process
    always_comb begin
        active_o = act_q;
        armed_o  = (state_q == SLOT_ARMED);
    end

endmodule

// File: rtl/plane_arm_fsm.sv
module plane_arm_fsm
    import plane_dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_evt,
    input  logic vblank,
    output logic pending
);

    bank_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: if (arm_evt) state_d = ARM_WAIT;
            ARM_WAIT: if (vblank && !arm_evt) state_d = ARM_IDLE;
            default:  state_d = ARM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARM_IDLE;
        else        state_q <= state_d;
    end

    always_comb pending = (state_q == ARM_WAIT);

endmodule

// File: rtl/plane_dbuf_regs.sv
module plane_dbuf_regs
    import plane_dbuf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned EN_BIT = DATA_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                vblank,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W-1:0]   act_ctrl,
    output logic [DATA_W-1:0]   act_surf,
    output logic [DATA_W-1:0]   act_stride,
    output logic [DATA_W-1:0]   act_pos,
    output logic [DATA_W-1:0]   act_size,
    output logic [DATA_W-1:0]   act_tileoff,
    output logic [DATA_W-1:0]   act_linoff,
    output logic [DATA_W-1:0]   act_offset,
    output logic [DATA_W-1:0]   act_key_lo,
    output logic [DATA_W-1:0]   act_key_hi,
    output logic [DATA_W-1:0]   act_key_mask,
    output logic [DATA_W-1:0]   act_csc,
    output logic [DATA_W-1:0]   act_scale,
    output logic                plane_on,
    output logic [DATA_W/2-1:0] disp_x,
    output logic [DATA_W/2-1:0] disp_y,
    output logic [DATA_W/2:0]   disp_w,
    output logic [DATA_W/2:0]   disp_h,
    output logic                upd_pending
);

    localparam int unsigned HALF = DATA_W / 2;

    logic [NUM_REGS-1:0] wr_hit;
    logic [NUM_REGS-1:0] self_arm;
    logic [NUM_REGS-1:0] armed_vec;
    logic                bank_arm;
    logic                arm_evt;
    logic [DATA_W-1:0]   act_q [NUM_REGS];

    plane_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .ctrl_enabled (act_q[REG_CTRL][EN_BIT]),
        .wr_hit       (wr_hit),
        .self_arm     (self_arm),
        .bank_arm     (bank_arm),
        .arm_evt      (arm_evt)
    );

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_slot
        plane_reg_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_hit[gi]),
            .wr_data  (wr_data),
            .self_arm (self_arm[gi]),
            .bank_arm (bank_arm),
            .vblank   (vblank),
            .active_o (act_q[gi]),
            .armed_o  (armed_vec[gi])
        );
    end

    plane_arm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_evt (arm_evt),
        .vblank  (vblank),
        .pending (upd_pending)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = act_q[i];
    end

    assign act_ctrl     = act_q[REG_CTRL];
    assign act_surf     = act_q[REG_SURF];
    assign act_stride   = act_q[REG_STRIDE];
    assign act_pos      = act_q[REG_POS];
    assign act_size     = act_q[REG_SIZE];
    assign act_tileoff  = act_q[REG_TILEOFF];
    assign act_linoff   = act_q[REG_LINOFF];
    assign act_offset   = act_q[REG_OFFSET];
    assign act_key_lo   = act_q[REG_KEYLO];
    assign act_key_hi   = act_q[REG_KEYHI];
    assign act_key_mask = act_q[REG_KEYMASK];
    assign act_csc      = act_q[REG_CSC];
    assign act_scale    = act_q[REG_SCALE];

    assign plane_on = act_q[REG_CTRL][EN_BIT];
    assign disp_x   = act_q[REG_POS][HALF-1:0];
    assign disp_y   = act_q[REG_POS][DATA_W-1:HALF];
    assign disp_w   = {1'b0, act_q[REG_SIZE][HALF-1:0]} + 1'b1;
    assign disp_h   = {1'b0, act_q[REG_SIZE][DATA_W-1:HALF]} + 1'b1;

endmodule

// File: rtl/plane_dbuf_regs_chk.sv
module plane_dbuf_regs_chk
    import plane_dbuf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned EN_BIT = DATA_W - 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                vblank,
    input logic [DATA_W-1:0]   act_ctrl,
    input logic [DATA_W-1:0]   act_surf,
    input logic [DATA_W-1:0]   act_tileoff,
    input logic [DATA_W-1:0]   act_stride,
    input logic                upd_pending,
    input logic [NUM_REGS-1:0] armed_vec
);

    p_stable_outside_vblank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank |=> ($stable(act_ctrl) && $stable(act_surf) &&
                     $stable(act_tileoff) && $stable(act_stride)));

    p_surface_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(REG_SURF)) |=> upd_pending);

    p_running_ctrl_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(REG_CTRL) && act_ctrl[EN_BIT] && !upd_pending)
        |=> !upd_pending);

    p_offsets_self_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_W'(REG_TILEOFF) || wr_addr == ADDR_W'(REG_LINOFF) ||
                   wr_addr == ADDR_W'(REG_OFFSET)  || wr_addr == ADDR_W'(REG_CSC)))
        |=> upd_pending);

    p_flag_tracks_slots_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pending == (|armed_vec));

    p_flag_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && upd_pending && !wr_en) |=> !upd_pending);

endmodule

bind plane_dbuf_regs plane_dbuf_regs_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .EN_BIT (EN_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .vblank      (vblank),
    .act_ctrl    (act_ctrl),
    .act_surf    (act_surf),
    .act_tileoff (act_tileoff),
    .act_stride  (act_stride),
    .upd_pending (upd_pending),
    .armed_vec   (armed_vec)
);

// File: tb/plane_dbuf_regs_test.sv
`timescale 1ns/1ps
module plane_dbuf_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        vblank = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] act_ctrl, act_surf, act_stride, act_pos, act_size, act_tileoff;
    logic [31:0] act_linoff, act_offset, act_key_lo, act_key_hi, act_key_mask;
    logic [31:0] act_csc, act_scale;
    logic        plane_on, upd_pending;
    logic [15:0] disp_x, disp_y;
    logic [16:0] disp_w, disp_h;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    plane_dbuf_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vblank(vblank), .rd_addr(rd_addr), .rd_data(rd_data),
        .act_ctrl(act_ctrl), .act_surf(act_surf), .act_stride(act_stride),
        .act_pos(act_pos), .act_size(act_size), .act_tileoff(act_tileoff),
        .act_linoff(act_linoff), .act_offset(act_offset), .act_key_lo(act_key_lo),
        .act_key_hi(act_key_hi), .act_key_mask(act_key_mask), .act_csc(act_csc),
        .act_scale(act_scale), .plane_on(plane_on), .disp_x(disp_x),
        .disp_y(disp_y), .disp_w(disp_w), .disp_h(disp_h),
        .upd_pending(upd_pending)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // one write, optionally in the same cycle as a vblank pulse
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic vb = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; vblank = vb;
        @(negedge clk);
        wr_en = 1'b0; vblank = 1'b0;
    endtask

    task automatic vb_pulse();
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        vblank = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ctrl", act_ctrl, 0);
        chk("R1 surf", act_surf, 0);
        chk("R1 plane_on", 32'(plane_on), 0);
        chk("R1 pending", 32'(upd_pending), 0);
    endtask

    task automatic t_bank_arm();
        wr(4'd2, 32'h0000_0100);
        wr(4'd3, {16'd20, 16'd10});
        chk("R7 no arm from stride/pos", 32'(upd_pending), 0);
        vb_pulse();
        vb_pulse();
        chk("R6 stride held", act_stride, 0);
        chk("R6 pos held", act_pos, 0);
        wr(4'd1, 32'h0000_1000);
        chk("R7 pending after surf", 32'(upd_pending), 1);
        chk("R2 surf before vblank", act_surf, 0);
        vb_pulse();
        chk("R3 surf", act_surf, 32'h1000);
        chk("R3 stride", act_stride, 32'h100);
        chk("R9 disp_x", 32'(disp_x), 10);
        chk("R9 disp_y", 32'(disp_y), 20);
        chk("R7 cleared", 32'(upd_pending), 0);
    endtask

    task automatic t_ctrl_arm();
        wr(4'd0, 32'h8000_0001);
        chk("R4 disabled ctrl arms", 32'(upd_pending), 1);
        vb_pulse();
        chk("R4 ctrl active", act_ctrl, 32'h8000_0001);
        chk("R4 plane_on", 32'(plane_on), 1);
        chk("R6 surf kept", act_surf, 32'h1000);
        wr(4'd0, 32'h8000_0003);
        chk("R4 enabled ctrl waits", 32'(upd_pending), 0);
        vb_pulse();
        chk("R4 ctrl unchanged", act_ctrl, 32'h8000_0001);
        wr(4'd1, 32'h0000_2000);
        vb_pulse();
        chk("R4 ctrl after surf", act_ctrl, 32'h8000_0003);
        chk("R3 surf 2", act_surf, 32'h2000);
    endtask

    task automatic t_self_arm();
        wr(4'd5, {16'd5, 16'd7});
        chk("R5 tileoff arms", 32'(upd_pending), 1);
        vb_pulse();
        chk("R5 tileoff", act_tileoff, {16'd5, 16'd7});
        chk("R9 tileoff y", 32'(act_tileoff[31:16]), 5);
        wr(4'd6, 32'h0000_0444);
        wr(4'd7, {16'd3, 16'd9});
        wr(4'd11, 32'h0123_4567);
        chk("R5 pending", 32'(upd_pending), 1);
        vb_pulse();
        chk("R5 linoff", act_linoff, 32'h444);
        chk("R5 offset", act_offset, {16'd3, 16'd9});
        chk("R5 csc", act_csc, 32'h0123_4567);
        chk("R6 surf untouched", act_surf, 32'h2000);
    endtask

    task automatic t_same_cycle();
        wr(4'd6, 32'h0000_0AAA);
        wr(4'd5, 32'h0000_0BBB, 1'b1);
        chk("R2 linoff transferred", act_linoff, 32'hAAA);
        chk("R2 tileoff not yet", act_tileoff, {16'd5, 16'd7});
        chk("R7 pending kept", 32'(upd_pending), 1);
        vb_pulse();
        chk("R2 tileoff next pulse", act_tileoff, 32'hBBB);
        chk("R7 pending cleared", 32'(upd_pending), 0);
    endtask

    task automatic t_size();
        wr(4'd4, {16'd479, 16'd639});
        wr(4'd12, 32'h0055_0055);
        wr(4'd8, 32'h0000_1111);
        wr(4'd1, 32'h0000_3000);
        vb_pulse();
        chk("R9 width", 32'(disp_w), 640);
        chk("R9 height", 32'(disp_h), 480);
        chk("R8 scaler", act_scale, 32'h0055_0055);
        chk("R8 key lo", act_key_lo, 32'h1111);
    endtask

    task automatic t_readback();
        @(negedge clk);
        rd_addr = 4'd3; #1;
        chk("R8 rd pos", rd_data, {16'd20, 16'd10});
        rd_addr = 4'd12; #1;
        chk("R8 rd scaler", rd_data, 32'h0055_0055);
        rd_addr = 4'd14; #1;
        chk("R8 rd out of range", rd_data, 0);
        wr(4'd14, 32'hDEAD_BEEF);
        chk("R8 bad write no arm", 32'(upd_pending), 0);
        rd_addr = 4'd14; #1;
        chk("R8 bad write no effect", rd_data, 0);
    endtask

    task automatic t_disable();
        wr(4'd0, 32'h0);
        wr(4'd12, 32'h0);
        chk("R10 no arm yet", 32'(upd_pending), 0);
        vb_pulse();
        chk("R10 still on", 32'(plane_on), 1);
        chk("R10 scaler kept", act_scale, 32'h0055_0055);
        wr(4'd1, 32'h0);
        chk("R10 armed", 32'(upd_pending), 1);
        chk("R10 on before blank", 32'(plane_on), 1);
        vb_pulse();
        chk("R10 ctrl off", act_ctrl, 0);
        chk("R10 scaler off", act_scale, 0);
        chk("R10 surf off", act_surf, 0);
        chk("R10 plane_on", 32'(plane_on), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog all-R actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank_arm();
        t_ctrl_arm();
        t_self_arm();
        t_same_cycle();
        t_size();
        t_readback();
        t_disable();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule